// File: doc/BRIEF.md
# Serial Link Rate Change Sequencer

This block steps a PCI Express style transceiver between its first-generation and second-generation line rates. User logic raises a one-cycle request that carries the wanted rate. The sequencer first confirms that the transmitter is at full power with electrical idle asserted. It then flips the rate-select bit that the transceiver watches and waits for the transceiver's one-cycle rate-done pulse. On that pulse it moves the user clock select between the 125 MHz and 250 MHz sources. The change is complete when the PHY raises its one-cycle status pulse. The sequencer then gives a one-cycle done pulse and goes back to idle.

A request that asks for the rate already in use finishes with a done pulse and leaves the rate bit alone. A request made while the preconditions are not met gives a one-cycle precondition error and changes nothing. A counter bounds each wait. If the rate-done pulse or the status pulse is missing for too long, the sequence aborts with a one-cycle timeout error. The clock generator, the glitch-free clock multiplexer and the transceiver all lie outside this block.

Top module: `rate_switch_seq`

## Requirements
- R1: Bit 1 of `tx_rate` reads 1 in every cycle, including during and after reset.
- R2: `rx_rate` equals `tx_rate` in every cycle.
- R3: The precondition holds only when `pwr_state` equals 2'b00 (full power) and `elec_idle` is 1. A request made when it does not hold gives exactly one `err_precond` pulse and no `done`, and leaves `tx_rate` and `clk_sel` unchanged.
- R4: A request whose `req_gen2` differs from `tx_rate[0]`, made with the precondition met, sets `tx_rate[0]` to `req_gen2` (1 = second generation) within four cycles of the request.
- R5: `clk_sel` changes only in the cycle after a `rate_done` pulse that arrives while the sequencer waits for it. It then takes the value of the new `tx_rate[0]` (0 = 125 MHz, 1 = 250 MHz).
- R6: `done` is a one-cycle pulse that follows a `phy_status` pulse accepted after the rate-done step. `busy` stays high from the request until the sequence ends.
- R7: A request for the rate already selected, with the precondition met, gives one `done` pulse and leaves `tx_rate` and `clk_sel` unchanged.
- R8: A request made while `busy` is high is ignored: it neither changes the target rate nor starts a second sequence.
- R9: If `rate_done` or `phy_status` is missing for TIMEOUT_CYC cycles in its wait, exactly one `err_timeout` pulse follows, no `done` is given, and `busy` falls.
- R10: After reset, `tx_rate` is 2'b10, `clk_sel` is 0 (125 MHz) and `busy`, `done`, `err_precond` and `err_timeout` are 0.
- R11: A `rate_done` or `phy_status` pulse that arrives outside its own wait state has no effect on `clk_sel`, `done` or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle rate change request |
| req_gen2 | input | 1 | Requested rate: 1 = second generation, 0 = first |
| pwr_state | input | 2 | Transmit power-down state; 2'b00 is full power |
| elec_idle | input | 1 | Transmit electrical idle is asserted |
| rate_done | input | 1 | One-cycle rate-done pulse from the transceiver |
| phy_status | input | 1 | One-cycle completion pulse from the PHY |
| tx_rate | output | 2 | Transmit rate control; bit 0 selects the rate |
| rx_rate | output | 2 | Receive rate control, copy of tx_rate |
| clk_sel | output | 1 | User clock select: 0 = 125 MHz, 1 = 250 MHz |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_precond | output | 1 | One-cycle pulse: request refused because the precondition failed |
| err_timeout | output | 1 | One-cycle pulse: a wait timed out |

## Verification
The assertions assume that the power state and the electrical-idle input do not change between a request and the cycle after it. They also assume that `rate_done` and `phy_status` are single-cycle pulses. The stimulus holds `pwr_state` and `elec_idle` steady across each request and drives each pulse for exactly one cycle, away from the clock edge. Stray pulses and requests arrive only while the sequencer is idle or waiting, so the ignore rules are exercised without breaking those assumptions.

// File: rtl/rate_switch_pkg.sv
package rate_switch_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CHECK   = 3'd1,
      ST_DRIVE   = 3'd2,
      ST_WAIT_RD = 3'd3,
      ST_WAIT_PS = 3'd4,
      ST_DONE    = 3'd5
   } seq_state_t;

   localparam logic RATE_GEN1 = 1'b0;
   localparam logic RATE_GEN2 = 1'b1;

endpackage

// File: rtl/rate_switch_timer.sv
module rate_switch_timer #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic expired
);
   localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   initial begin
      if (LIMIT < 2) $error("rate_switch_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || clr) cnt_q <= '0;
      else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && !clr && (cnt_q == LAST);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R9
   AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!run) |-> (cnt_q == '0)); // R9

endmodule

// File: rtl/rate_switch_drive.sv
module rate_switch_drive #(
   parameter bit FAST_SEL_HIGH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_rate,
   input  logic       target,
   input  logic       load_clk,
   output logic [1:0] rate_o,
   output logic       clk_sel_o
);
   logic rate_bit_q;
   logic fast_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         rate_bit_q <= 1'b0;
      else if (load_rate) rate_bit_q <= target;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        fast_q <= 1'b0;
      else if (load_clk) fast_q <= rate_bit_q;
   end

   assign rate_o = {1'b1, rate_bit_q};

   generate
      if (FAST_SEL_HIGH) begin : g_sel_pos
         assign clk_sel_o = fast_q;
      end else begin : g_sel_neg
         assign clk_sel_o = ~fast_q;
      end
   endgenerate

   AST_RATE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rate_bit_q) |-> $past(load_rate)); // R4
   AST_FAST_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fast_q) |-> $past(load_clk)); // R5

endmodule

// File: rtl/rate_switch_fsm.sv
module rate_switch_fsm
   import rate_switch_pkg::*;
#(
   parameter int          PWR_W   = 2,
   parameter logic [PWR_W-1:0] P0_CODE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_gen2,
   input  logic [PWR_W-1:0] pwr_state,
   input  logic             elec_idle,
   input  logic             rate_done,
   input  logic             phy_status,
   input  logic             cur_rate,
   input  logic             expired,
   output logic             load_rate,
   output logic             target,
   output logic             load_clk,
   output logic             timer_run,
   output logic             timer_clr,
   output logic             busy,
   output logic             done,
   output logic             err_precond,
   output logic             err_timeout
);
   seq_state_t state_q, state_d;
   logic       tgt_q;
   logic       epre_q, eto_q;
   logic       cond_ok;

   assign cond_ok = (pwr_state == P0_CODE) && elec_idle;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (req) state_d = ST_CHECK;
         ST_CHECK: begin
            if (!cond_ok)              state_d = ST_IDLE;
            else if (tgt_q == cur_rate) state_d = ST_DONE;
            else                       state_d = ST_DRIVE;
         end
         ST_DRIVE:   state_d = ST_WAIT_RD;
         ST_WAIT_RD: begin
            if (rate_done)    state_d = ST_WAIT_PS;
            else if (expired) state_d = ST_IDLE;
         end
         ST_WAIT_PS: begin
            if (phy_status)   state_d = ST_DONE;
            else if (expired) state_d = ST_IDLE;
         end
         ST_DONE:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tgt_q   <= RATE_GEN1;
         epre_q  <= 1'b0;
         eto_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req) tgt_q <= req_gen2;
         epre_q <= (state_q == ST_CHECK) && !cond_ok;
         eto_q  <= ((state_q == ST_WAIT_RD) && !rate_done && expired) ||
                   ((state_q == ST_WAIT_PS) && !phy_status && expired);
      end
   end

   assign load_rate   = (state_q == ST_DRIVE);
   assign target      = tgt_q;
   assign load_clk    = (state_q == ST_WAIT_RD) && rate_done;
   assign timer_run   = (state_q == ST_WAIT_RD) || (state_q == ST_WAIT_PS);
   assign timer_clr   = load_clk;
   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_DONE);
   assign err_precond = epre_q;
   assign err_timeout = eto_q;

   AST_DRIVE_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DRIVE) |-> $past(cond_ok)); // R3
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_precond || err_timeout) |-> !done); // R9
   AST_TIMEOUT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> (state_q == ST_IDLE)); // R9
   AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(tgt_q)); // R8

endmodule

// File: rtl/rate_switch_seq.sv
module rate_switch_seq #(
   parameter int TIMEOUT_CYC   = 1024,
   parameter int PWR_W         = 2,
   parameter bit FAST_SEL_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_gen2,
   input  logic [PWR_W-1:0] pwr_state,
   input  logic             elec_idle,
   input  logic             rate_done,
   input  logic             phy_status,
   output logic [1:0]       tx_rate,
   output logic [1:0]       rx_rate,
   output logic             clk_sel,
   output logic             busy,
   output logic             done,
   output logic             err_precond,
   output logic             err_timeout
);
   localparam logic [PWR_W-1:0] P0_CODE = '0;

   initial begin
      if (PWR_W < 1) $error("rate_switch_seq: PWR_W must be positive");
   end

   logic load_rate, target, load_clk, timer_run, timer_clr, expired;
   logic [1:0] rate_w;

   rate_switch_fsm #(.PWR_W(PWR_W), .P0_CODE(P0_CODE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .req_gen2(req_gen2),
      .pwr_state(pwr_state), .elec_idle(elec_idle),
      .rate_done(rate_done), .phy_status(phy_status),
      .cur_rate(rate_w[0]), .expired(expired),
      .load_rate(load_rate), .target(target), .load_clk(load_clk),
      .timer_run(timer_run), .timer_clr(timer_clr),
      .busy(busy), .done(done),
      .err_precond(err_precond), .err_timeout(err_timeout)
   );

   rate_switch_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(timer_run), .clr(timer_clr),
      .expired(expired)
   );

   rate_switch_drive #(.FAST_SEL_HIGH(FAST_SEL_HIGH)) u_drive (
      .clk(clk), .rst_n(rst_n), .load_rate(load_rate), .target(target),
      .load_clk(load_clk), .rate_o(rate_w), .clk_sel_o(clk_sel)
   );

   assign tx_rate = rate_w;
   assign rx_rate = rate_w;

   AST_RATE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rate[1] == 1'b1); // R1
   AST_CLKSEL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clk_sel) |-> ($past(rate_done) && $past(busy))); // R5
   AST_RATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_rate) |-> $past(busy)); // R4
   AST_PRECOND_HOLDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      err_precond |-> ($stable(tx_rate) && $stable(clk_sel))); // R3

endmodule

// File: tb/rate_switch_seq_test.sv
module rate_switch_seq_test;
   localparam int TO = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, req_gen2 = 1'b0, elec_idle = 1'b1;
   logic [1:0] pwr_state = 2'b00;
   logic rate_done = 1'b0, phy_status = 1'b0;
   logic [1:0] tx_rate, rx_rate;
   logic clk_sel, busy, done, err_precond, err_timeout;

   int checks = 0, errors = 0;
   int n_done = 0, n_epre = 0, n_eto = 0;
   logic exp_rate = 1'b0, exp_clk = 1'b0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rate_switch_seq #(.TIMEOUT_CYC(TO)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_gen2(req_gen2),
      .pwr_state(pwr_state), .elec_idle(elec_idle),
      .rate_done(rate_done), .phy_status(phy_status),
      .tx_rate(tx_rate), .rx_rate(rx_rate), .clk_sel(clk_sel),
      .busy(busy), .done(done), .err_precond(err_precond),
      .err_timeout(err_timeout)
   );

   always @(negedge clk) begin
      if (done)        n_done++;
      if (err_precond) n_epre++;
      if (err_timeout) n_eto++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_counts();
      step(1);
      n_done = 0; n_epre = 0; n_eto = 0;
   endtask

   task automatic pulse_req(input logic g);
      req = 1'b1; req_gen2 = g; step(1); req = 1'b0;
   endtask

   task automatic pulse_rd();
      rate_done = 1'b1; step(1); rate_done = 1'b0;
   endtask

   task automatic pulse_ps();
      phy_status = 1'b1; step(1); phy_status = 1'b0;
   endtask

   task automatic check_rates(input string tag);
      chk(tx_rate == {1'b1, exp_rate}, {tag, " R1 R4 tx_rate"}, tx_rate, {1'b1, exp_rate});
      chk(rx_rate == tx_rate, {tag, " R2 rx mirror"}, rx_rate, tx_rate);
      chk(clk_sel == exp_clk, {tag, " R5 clk_sel"}, clk_sel, exp_clk);
   endtask

   task automatic t_reset();
      step(1);
      chk(tx_rate == 2'b10, "R10 reset tx_rate", tx_rate, 2);
      chk(clk_sel == 1'b0, "R10 reset clk_sel", clk_sel, 0);
      chk({busy, done, err_precond, err_timeout} == 4'b0, "R10 reset flags",
          {busy, done, err_precond, err_timeout}, 0);
      chk(rx_rate == tx_rate, "R2 reset mirror", rx_rate, tx_rate);
   endtask

   task automatic t_precond(input logic [1:0] pw, input logic ei);
      clear_counts();
      pwr_state = pw; elec_idle = ei;
      pulse_req(~exp_rate);
      step(6);
      chk(n_epre == 1, "R3 precond error pulses", n_epre, 1);
      chk(n_done == 0, "R3 no done", n_done, 0);
      chk(busy == 1'b0, "R3 idle after refusal", busy, 0);
      check_rates("R3");
      pwr_state = 2'b00; elec_idle = 1'b1;
   endtask

   task automatic t_change(input int rd_delay);
      logic tgt;
      tgt = ~exp_rate;
      clear_counts();
      pulse_req(tgt);
      step(4);
      exp_rate = tgt;
      check_rates("R4 after drive");
      chk(busy == 1'b1, "R6 busy while waiting", busy, 1);
      pulse_ps();                  // stray status before rate-done, R11
      step(2);
      chk(n_done == 0 && busy, "R11 early phy_status ignored", n_done, 0);
      pulse_req(~tgt);             // request while busy, R8
      step(2);
      chk(tx_rate[0] == tgt, "R8 busy request ignored", tx_rate[0], tgt);
      step(rd_delay);
      pulse_rd();
      step(1);
      exp_clk = tgt;
      check_rates("R5 after rate_done");
      step(2);
      chk(n_done == 0, "R6 no done before phy_status", n_done, 0);
      pulse_ps();
      step(3);
      chk(n_done == 1, "R6 one done pulse", n_done, 1);
      chk(busy == 1'b0, "R6 busy cleared", busy, 0);
      step(5);
      chk(n_done == 1 && !busy && n_epre == 0, "R8 no second sequence", n_done, 1);
      check_rates("R8 final");
   endtask

   task automatic t_same_rate();
      clear_counts();
      pulse_req(exp_rate);
      step(5);
      chk(n_done == 1, "R7 same-rate done", n_done, 1);
      check_rates("R7");
   endtask

   task automatic t_stray_idle();
      clear_counts();
      pulse_rd(); step(1); pulse_ps(); step(3);
      chk(!busy && n_done == 0, "R11 idle pulses ignored", n_done, 0);
      check_rates("R11 idle");
   endtask

   task automatic t_timeout_rd();
      clear_counts();
      pulse_req(~exp_rate);
      step(4);
      exp_rate = ~exp_rate;
      step(TO + 10);
      chk(n_eto == 1, "R9 rate_done timeout", n_eto, 1);
      chk(n_done == 0 && !busy, "R9 no done after timeout", n_done, 0);
      check_rates("R9 rd");
   endtask

   task automatic t_timeout_ps();
      clear_counts();
      pulse_req(~exp_rate);
      step(4);
      exp_rate = ~exp_rate;
      pulse_rd();
      step(1);
      exp_clk = exp_rate;
      check_rates("R9 ps clk");
      step(TO + 10);
      chk(n_eto == 1, "R9 phy_status timeout", n_eto, 1);
      chk(n_done == 0 && !busy, "R9 idle after timeout", n_done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_precond(2'b10, 1'b1);
      t_precond(2'b00, 1'b0);
      t_stray_idle();
      t_same_rate();
      t_change(3);
      t_same_rate();
      t_change(0);
      t_timeout_rd();
      t_change(7);
      t_timeout_ps();
      t_change(1);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule